// File: doc/BRIEF.md
# Pipeline Interlock Stall Detector

This block decides, every cycle, whether the instruction waiting at the decode slot of a short in-order DSP pipeline may issue or must be held. It looks at decoded descriptor fields of that waiting instruction and compares them with what recently issued instructions left behind. Four interlocks are covered. The first is a multiply whose two operands both come from the compute instruction just before it. The second is any instruction following a mode-register change, whether that change is a direct write, a bit set/clear, a status-stack push/pop, or the automatic status save/restore on hardware or timer interrupt entry and return. The third is a return following a load of the return-address stack. The fourth is an index register reused after a conditional access that post-modifies it.

Each issued producer arms a small countdown. The countdown decays by one every clock, whether the cycle is a stall, a bubble or an issue. A consumer stalls while a matching countdown is non-zero. When several interlocks match at once, their requests are merged. The block reports the stall and the number of stall cycles still to come. The decoder must hold the stalled instruction's fields unchanged, so the stall can be evaluated again each cycle and ends by itself.

Top module: `ilk_stall_unit`

## Requirements
- R1: A valid multiply stalls for MUL_LAT cycles (default 1) when the compute instruction issued in the immediately preceding cycle wrote both of its source registers. Result slot d of `res_regs` is bits [d*REG_W +: REG_W] and is enabled by `res_en[d]`. Two sources naming the same produced register count as both produced.
- R2: A multiply does not stall when only one of its sources was produced. It also does not stall when a bubble cycle separates it from the producer.
- R3: After an issued instruction with `mode_wr` set (direct write or bit set/clear), the next valid instruction of any kind stalls MODE_LAT cycles (default 1). A one-cycle gap removes the stall.
- R4: An issued instruction with `stat_stk_op` set (status push/pop, or interrupt entry/return that saves or restores status) causes the same stall as R3.
- R5: A return (`ret_op`) immediately after an issued `pcstk_wr` stalls PCS_LAT cycles (default 1). A non-return, or a return after a gap, does not stall.
- R6: After an issued `cond_postmod` on index register `idx_reg`, a valid instruction with `idx_use` on the same register stalls for IDX_LAT cycles (default 2) less the number of cycles elapsed since the producer issued. A different index register does not stall. Each index register is tracked separately.
- R7: `periph_acc` and `dma_bank_hit` on the producer never remove or shorten a stall.
- R8: When several interlocks match at once, the stall lasts as long as the longest of them. While stalling, `stall_left` holds the number of stall cycles still to come, including the current one, and it falls by one per cycle while inputs are held. When `stall` is low, `stall_left` is 0.
- R9: Once its stall cycles are spent, a held instruction issues. The interlock that held it does not stall the following instruction.
- R10: `stall` is low during reset and whenever `ins_valid` is low. Reset discards every pending interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An instruction occupies the decode slot |
| mul_op | input | 1 | Instruction is a multiply |
| src_a | input | REG_W | First multiply source register |
| src_b | input | REG_W | Second multiply source register |
| res_en | input | NDST | Enables per compute result slot |
| res_regs | input | NDST*REG_W | Destination registers of compute results |
| mode_wr | input | 1 | Writes a mode register (direct or bit set/clear) |
| stat_stk_op | input | 1 | Status-stack push/pop, including interrupt entry/return |
| pcstk_wr | input | 1 | Loads the return-address stack |
| ret_op | input | 1 | Return from subroutine or interrupt |
| cond_postmod | input | 1 | Conditional access post-modifying `idx_reg` |
| idx_reg | input | IDX_W | Index register named by the instruction |
| idx_use | input | 1 | Instruction reads `idx_reg` |
| periph_acc | input | 1 | Memory access targets a peripheral register |
| dma_bank_hit | input | 1 | DMA hits the same bank as the access |
| stall | output | 1 | Hold the decode slot this cycle |
| stall_left | output | 4 | Stall cycles still to come, including this one |

## Verification
Producer and consumer pairs are played with zero, one and two idle cycles between them. This separates a hazard that expires with time from one that stays pending forever. Multiply pairs use both source orders, a single shared register, and a partial operand match, which separates "both produced" from "either produced". Index cases use the same and a different register. Combined producers check that the longest interlock sets the stall length. The peripheral and DMA sideband variants must give the same stall count as the plain ones.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // stall counts are carried in a fixed 4-bit field; every latency parameter must be <= 15
  localparam int unsigned LAT_W = 4;
  typedef logic [LAT_W-1:0] lat_t;

  function automatic lat_t lat_max(input lat_t a, input lat_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic lat_t lat_gate(input logic hit, input lat_t c);
    return hit ? c : '0;
  endfunction
endpackage

// File: rtl/ilk_hold_timer.sv
module ilk_hold_timer
  import ilk_pkg::*;
#(
  parameter int unsigned LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output lat_t cnt
);
  localparam lat_t LOAD_VAL = lat_t'(LAT);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= LOAD_VAL;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  AST_TIMER_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == lat_t'(1) && !load) |=> (cnt == '0)); // R9
endmodule

// File: rtl/ilk_mul_track.sv
module ilk_mul_track
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W = 4,
  parameter int unsigned NDST  = 2,
  parameter int unsigned LAT   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue,
  input  logic [NDST-1:0]       res_en,
  input  logic [NDST*REG_W-1:0] res_regs,
  input  logic                  mul_op,
  input  logic [REG_W-1:0]      src_a,
  input  logic [REG_W-1:0]      src_b,
  output logic                  hit,
  output lat_t                  cnt
);
  logic [NDST-1:0]       en_q;
  logic [NDST*REG_W-1:0] regs_q;
  logic [NDST-1:0]       match_a, match_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      regs_q <= '0;
    end else if (issue) begin
      en_q   <= res_en;
      regs_q <= res_regs;
    end
  end

  ilk_hold_timer #(.LAT(LAT)) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .load (issue && (res_en != '0)),
    .cnt  (cnt)
  );

  for (genvar d = 0; d < NDST; d++) begin : g_slot
    assign match_a[d] = en_q[d] && (regs_q[d*REG_W +: REG_W] == src_a);
    assign match_b[d] = en_q[d] && (regs_q[d*REG_W +: REG_W] == src_b);
  end

  assign hit = mul_op && (cnt != '0) && (|match_a) && (|match_b);
endmodule

// File: rtl/ilk_idx_track.sv
module ilk_idx_track
  import ilk_pkg::*;
#(
  parameter int unsigned NIDX = 8,
  parameter int unsigned LAT  = 2,
  localparam int unsigned IDX_W = (NIDX > 1) ? $clog2(NIDX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             cond_postmod,
  input  logic [IDX_W-1:0] idx,
  input  logic             idx_use,
  output logic             hit,
  output lat_t             cnt
);
  logic [NIDX-1:0] load_vec;
  lat_t            cnt_arr [NIDX];
  logic            armed;

  for (genvar i = 0; i < NIDX; i++) begin : g_reg
    assign load_vec[i] = issue && cond_postmod && (idx == IDX_W'(i));
    ilk_hold_timer #(.LAT(LAT)) u_t (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load_vec[i]),
      .cnt  (cnt_arr[i])
    );
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NIDX; i++)
      if (idx == IDX_W'(i)) cnt = cnt_arr[i];
  end

  assign hit = idx_use && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_IDX_REUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && idx_use && $past(issue && cond_postmod) && (idx == $past(idx))) |-> hit); // R6
endmodule

// File: rtl/ilk_stall_unit.sv
module ilk_stall_unit
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W    = 4,
  parameter int unsigned NDST     = 2,
  parameter int unsigned NIDX     = 8,
  parameter int unsigned MUL_LAT  = 1,
  parameter int unsigned MODE_LAT = 1,
  parameter int unsigned PCS_LAT  = 1,
  parameter int unsigned IDX_LAT  = 2,
  localparam int unsigned IDX_W = (NIDX > 1) ? $clog2(NIDX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_valid,
  input  logic                  mul_op,
  input  logic [REG_W-1:0]      src_a,
  input  logic [REG_W-1:0]      src_b,
  input  logic [NDST-1:0]       res_en,
  input  logic [NDST*REG_W-1:0] res_regs,
  input  logic                  mode_wr,
  input  logic                  stat_stk_op,
  input  logic                  pcstk_wr,
  input  logic                  ret_op,
  input  logic                  cond_postmod,
  input  logic [IDX_W-1:0]      idx_reg,
  input  logic                  idx_use,
  input  logic                  periph_acc,
  input  logic                  dma_bank_hit,
  output logic                  stall,
  output lat_t                  stall_left
);
  localparam int unsigned BUS_W = 10 + 2*REG_W + NDST*(REG_W+1) + IDX_W;

  // internal events, named for the assertions
  logic issue;
  logic mul_hit, mode_hit, pcs_hit, idx_hit;
  lat_t mul_cnt, mode_cnt, pcs_cnt, idx_cnt;
  logic armed;
  logic [BUS_W-1:0] ins_bus;

  assign issue = ins_valid && !stall;

  ilk_mul_track #(.REG_W(REG_W), .NDST(NDST), .LAT(MUL_LAT)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .res_en  (res_en),
    .res_regs(res_regs),
    .mul_op  (mul_op),
    .src_a   (src_a),
    .src_b   (src_b),
    .hit     (mul_hit),
    .cnt     (mul_cnt)
  );

  ilk_hold_timer #(.LAT(MODE_LAT)) u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .load (issue && (mode_wr || stat_stk_op)),
    .cnt  (mode_cnt)
  );

  ilk_hold_timer #(.LAT(PCS_LAT)) u_pcs (
    .clk  (clk),
    .rst_n(rst_n),
    .load (issue && pcstk_wr),
    .cnt  (pcs_cnt)
  );

  ilk_idx_track #(.NIDX(NIDX), .LAT(IDX_LAT)) u_idx (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .cond_postmod(cond_postmod),
    .idx         (idx_reg),
    .idx_use     (idx_use),
    .hit         (idx_hit),
    .cnt         (idx_cnt)
  );

  assign mode_hit = (mode_cnt != '0);
  assign pcs_hit  = ret_op && (pcs_cnt != '0);

  assign stall = ins_valid && (mul_hit || mode_hit || pcs_hit || idx_hit);

  always_comb begin
    stall_left = '0;
    if (stall)
      stall_left = lat_max(lat_max(lat_gate(mul_hit, mul_cnt), lat_gate(mode_hit, mode_cnt)),
                           lat_max(lat_gate(pcs_hit, pcs_cnt), lat_gate(idx_hit, idx_cnt)));
  end

  // ---------------------------------------------------------------- checks
  function automatic logic both_from(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                                     input logic [NDST*REG_W-1:0] regs, input logic [NDST-1:0] en);
    logic fa, fb;
    fa = 1'b0;
    fb = 1'b0;
    for (int d = 0; d < NDST; d++) begin
      if (en[d] && regs[d*REG_W +: REG_W] == a) fa = 1'b1;
      if (en[d] && regs[d*REG_W +: REG_W] == b) fb = 1'b1;
    end
    return fa && fb;
  endfunction

  assign ins_bus = {ins_valid, mul_op, src_a, src_b, res_en, res_regs, mode_wr, stat_stk_op,
                    pcstk_wr, ret_op, cond_postmod, idx_reg, idx_use, periph_acc, dma_bank_hit};

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_MUL_BOTH_FED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ins_valid && mul_op && $past(issue) &&
     both_from(src_a, src_b, $past(res_regs), $past(res_en))) |-> stall); // R1

  AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ins_valid && $past(issue && mode_wr)) |-> (stall && stall_left >= lat_t'(MODE_LAT))); // R3

  AST_STACK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ins_valid && $past(issue && stat_stk_op)) |-> stall); // R4

  AST_RET_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ins_valid && ret_op && $past(issue && pcstk_wr)) |-> stall); // R5

  AST_SIDEBAND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ins_valid && $past(issue && (mode_wr || pcstk_wr) && (periph_acc || dma_bank_hit))
     && (ret_op || !$past(pcstk_wr) || $past(mode_wr))) |-> stall); // R7

  AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_left != '0)); // R8

  AST_LEFT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && stall && $past(stall) && $stable(ins_bus)) |-> (stall_left == $past(stall_left) - 1'b1)); // R8
endmodule

// File: tb/test_ilk_stall_unit.sv
module test_ilk_stall_unit;
  localparam int REG_W = 4;
  localparam int NDST  = 2;
  localparam int IDX_W = 3;

  localparam logic [3:0] K_NOP = 4'd0, K_DUAL = 4'd1, K_MUL = 4'd2, K_MODE = 4'd3,
                         K_BIT = 4'd4, K_STK = 4'd5, K_IRQ = 4'd6, K_PCS = 4'd7,
                         K_RET = 4'd8, K_CPM = 4'd9, K_IUSE = 4'd10, K_MODEP = 4'd11,
                         K_PCSD = 4'd12, K_ALU1 = 4'd13, K_MULTI = 4'd14, K_MULIDX = 4'd15;

  // {prod kind, pa, pb, gap, cons kind, ca, cb, expected stalls, requirement}
  localparam int NV = 21;
  localparam logic [33:0] VEC [NV] = '{
    {K_DUAL,  4'd1, 4'd2, 2'd0, K_MUL,    4'd1, 4'd2, 4'd1, 4'd1},  // R1
    {K_DUAL,  4'd1, 4'd2, 2'd0, K_MUL,    4'd2, 4'd1, 4'd1, 4'd1},  // R1
    {K_ALU1,  4'd4, 4'd0, 2'd0, K_MUL,    4'd4, 4'd4, 4'd1, 4'd1},  // R1
    {K_DUAL,  4'd1, 4'd2, 2'd0, K_MUL,    4'd1, 4'd3, 4'd0, 4'd2},  // R2
    {K_DUAL,  4'd1, 4'd2, 2'd1, K_MUL,    4'd1, 4'd2, 4'd0, 4'd2},  // R2
    {K_MODE,  4'd0, 4'd0, 2'd0, K_NOP,    4'd0, 4'd0, 4'd1, 4'd3},  // R3
    {K_BIT,   4'd0, 4'd0, 2'd0, K_RET,    4'd0, 4'd0, 4'd1, 4'd3},  // R3
    {K_MODE,  4'd0, 4'd0, 2'd1, K_NOP,    4'd0, 4'd0, 4'd0, 4'd3},  // R3
    {K_STK,   4'd0, 4'd0, 2'd0, K_IUSE,   4'd3, 4'd0, 4'd1, 4'd4},  // R4
    {K_IRQ,   4'd0, 4'd0, 2'd0, K_NOP,    4'd0, 4'd0, 4'd1, 4'd4},  // R4
    {K_PCS,   4'd0, 4'd0, 2'd0, K_RET,    4'd0, 4'd0, 4'd1, 4'd5},  // R5
    {K_PCS,   4'd0, 4'd0, 2'd0, K_NOP,    4'd0, 4'd0, 4'd0, 4'd5},  // R5
    {K_PCS,   4'd0, 4'd0, 2'd1, K_RET,    4'd0, 4'd0, 4'd0, 4'd5},  // R5
    {K_CPM,   4'd3, 4'd0, 2'd0, K_IUSE,   4'd3, 4'd0, 4'd2, 4'd6},  // R6
    {K_CPM,   4'd3, 4'd0, 2'd1, K_IUSE,   4'd3, 4'd0, 4'd1, 4'd6},  // R6
    {K_CPM,   4'd3, 4'd0, 2'd2, K_IUSE,   4'd3, 4'd0, 4'd0, 4'd6},  // R6
    {K_CPM,   4'd3, 4'd0, 2'd0, K_IUSE,   4'd4, 4'd0, 4'd0, 4'd6},  // R6
    {K_MODEP, 4'd0, 4'd0, 2'd0, K_NOP,    4'd0, 4'd0, 4'd1, 4'd7},  // R7
    {K_PCSD,  4'd0, 4'd0, 2'd0, K_RET,    4'd0, 4'd0, 4'd1, 4'd7},  // R7
    {K_MULTI, 4'd5, 4'd6, 2'd0, K_MULIDX, 4'd5, 4'd6, 4'd2, 4'd8},  // R8
    {K_MULTI, 4'd5, 4'd6, 2'd1, K_MULIDX, 4'd5, 4'd6, 4'd1, 4'd8}   // R8
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic ins_valid, mul_op, mode_wr, stat_stk_op, pcstk_wr, ret_op, cond_postmod, idx_use;
  logic periph_acc, dma_bank_hit, stall;
  logic [REG_W-1:0] src_a, src_b;
  logic [NDST-1:0] res_en;
  logic [NDST*REG_W-1:0] res_regs;
  logic [IDX_W-1:0] idx_reg;
  logic [3:0] stall_left;

  ilk_stall_unit i_ilk_stall_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .mul_op(mul_op),
    .src_a(src_a), .src_b(src_b), .res_en(res_en), .res_regs(res_regs),
    .mode_wr(mode_wr), .stat_stk_op(stat_stk_op), .pcstk_wr(pcstk_wr), .ret_op(ret_op),
    .cond_postmod(cond_postmod), .idx_reg(idx_reg), .idx_use(idx_use),
    .periph_acc(periph_acc), .dma_bank_hit(dma_bank_hit),
    .stall(stall), .stall_left(stall_left)
  );

  int n_cmp = 0;
  int n_bad = 0;

  function automatic string rq(input logic [3:0] n);
    case (n)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";  4'd4: return "R4";
      4'd5: return "R5";  4'd6: return "R6";  4'd7: return "R7";  4'd8: return "R8";
      4'd9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] kind, input logic [3:0] a, input logic [3:0] b, input logic v);
    ins_valid = v; mul_op = 0; src_a = '0; src_b = '0; res_en = '0; res_regs = '0;
    mode_wr = 0; stat_stk_op = 0; pcstk_wr = 0; ret_op = 0; cond_postmod = 0;
    idx_reg = '0; idx_use = 0; periph_acc = 0; dma_bank_hit = 0;
    case (kind)
      K_DUAL:   begin res_en = 2'b11; res_regs = {b, a}; end
      K_ALU1:   begin res_en = 2'b01; res_regs = {4'd0, a}; end
      K_MUL:    begin mul_op = 1; src_a = a; src_b = b; end
      K_MODE, K_BIT: mode_wr = 1;
      K_STK, K_IRQ:  stat_stk_op = 1;
      K_PCS:    pcstk_wr = 1;
      K_RET:    ret_op = 1;
      K_CPM:    begin cond_postmod = 1; idx_use = 1; idx_reg = a[2:0]; end
      K_IUSE:   begin idx_use = 1; idx_reg = a[2:0]; end
      K_MODEP:  begin mode_wr = 1; periph_acc = 1; end
      K_PCSD:   begin pcstk_wr = 1; dma_bank_hit = 1; end
      K_MULTI:  begin mode_wr = 1; cond_postmod = 1; idx_use = 1; idx_reg = a[2:0];
                      res_en = 2'b11; res_regs = {b, a}; end
      K_MULIDX: begin mul_op = 1; src_a = a; src_b = b; idx_use = 1; idx_reg = a[2:0]; end
      default: ;
    endcase
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0;
    drive(K_RET, 0, 0, 1);
    @(negedge clk);
    chk(!stall && stall_left == 0, "R10", "stall during reset", int'(stall), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1; drive(K_NOP, 0, 0, 0);
    @(negedge clk);
    chk(stall_left == 0, "R10", "stall_left after reset", int'(stall_left), 0);
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      automatic logic [3:0] pk = VEC[v][33:30], pa = VEC[v][29:26], pb = VEC[v][25:22];
      automatic logic [1:0] gap = VEC[v][21:20];
      automatic logic [3:0] ck = VEC[v][19:16], ca = VEC[v][15:12], cb = VEC[v][11:8];
      automatic int exp = int'(VEC[v][7:4]);
      automatic string req = rq(VEC[v][3:0]);
      automatic int nst = 0;
      drive(pk, pa, pb, 1);
      @(negedge clk);
      chk(!stall, req, "producer stalled on clean pipe", int'(stall), 0);
      @(posedge clk); #1;
      for (int g = 0; g < int'(gap); g++) begin
        drive(K_NOP, 0, 0, 0);
        @(posedge clk); #1;
      end
      drive(ck, ca, cb, 1);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (!stall) break;
        chk(int'(stall_left) == exp - c, "R8", "stall_left countdown", int'(stall_left), exp - c);
        nst++;
        @(posedge clk); #1;
      end
      chk(stall_left == 0, "R8", "stall_left while issuing", int'(stall_left), 0);
      chk(nst == exp, req, "stall cycles", nst, exp);
      @(posedge clk); #1;
      drive(K_NOP, 0, 0, 1);
      @(negedge clk);
      chk(!stall, "R9", "stall after held instruction issued", int'(stall), 0);
      @(posedge clk); #1;
      drive(K_NOP, 0, 0, 0);
      repeat (3) @(posedge clk);
      #1;
    end

    // R10: a bubble slot never stalls, then the R6 hazard resumes with one cycle left
    drive(K_CPM, 1, 0, 1);
    @(posedge clk); #1;
    drive(K_IUSE, 1, 0, 0);
    @(negedge clk);
    chk(!stall, "R10", "stall on empty slot", int'(stall), 0);
    @(posedge clk); #1;
    drive(K_IUSE, 1, 0, 1);
    @(negedge clk);
    chk(stall && stall_left == 1, "R6", "stall_left after one bubble", int'(stall_left), 1);
    @(posedge clk); #1;
    drive(K_NOP, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;

    // R10: reset discards a pending index interlock
    drive(K_CPM, 2, 0, 1);
    @(posedge clk); #1;
    rst_n = 0;
    drive(K_IUSE, 2, 0, 1);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(!stall, "R10", "pending hazard survived reset", int'(stall), 0);
    @(posedge clk); #1;
    drive(K_NOP, 0, 0, 0);
    @(posedge clk);

    summary();
    $finish;
  end
endmodule